// File: doc/BRIEF.md
# Bridge Short and Over-Temperature Fault Supervisor

This block watches the overcurrent comparators of every switch in a set of H-bridge channels, together with a single over-temperature flag, and decides when the bridges must be switched off. A comparator output counts as a short only after it has stayed high for a configurable number of consecutive clock cycles. Shorter glitches are discarded, because the persistence counter of that switch starts again from zero each time its flag drops. A confirmed short is latched. It is released only when the chip enable input goes low, which puts the whole block into standby and clears all of its state.

The reach of a short depends on the drive mode. In stepper mode every channel is disabled. In dual DC-motor mode only the channel that shorted is disabled, and the others keep running. An over-temperature condition disables all channels for as long as the flag is present, and the outputs recover by themselves once it clears. Both fault kinds pull a registered, active-low warning output. When a switch flag is already high while the chopper is in its forced-charge blanking window, the block asks the chopper to stay in charge. This gives the short time to persist long enough to be confirmed.

Top module: `short_fault_mgr`

## Requirements
- R1: While `run_en` is low, `bridge_off` is all zeros, `hold_charge` is all zeros and `warn_n` is 1. Driving `run_en` low also erases any latched short.
- R2: Flag bit `c*NSW+s` belongs to switch `s` of channel `c`. If such a flag is high at PERSIST_CYC consecutive rising edges, a short is latched for channel `c` on the last of those edges. The disable appears on `bridge_off` one edge later. PERSIST_CYC-1 consecutive edges latch nothing.
- R3: If a flag is low at even one edge, its persistence count restarts. Two high runs of PERSIST_CYC-1 edges each, separated by one low edge, latch nothing.
- R4: With `dc_mode`=0 (stepper), a latched short on any channel sets every bit of `bridge_off`.
- R5: With `dc_mode`=1 (independent DC), a latched short sets only the `bridge_off` bit of its own channel.
- R6: A latched short persists after its flag deasserts and remains in force until `run_en` goes low.
- R7: `thermal_flag` sampled high sets every bit of `bridge_off` two edges later. Two edges after it is sampled low, `bridge_off` returns to the state the latched shorts alone call for.
- R8: `warn_n` is registered. It is 0 exactly when at least one `bridge_off` bit is 1, and it is 1 otherwise.
- R9: `hold_charge[c]` rises one edge after any flag of channel `c` is sampled high while `chg_blank[c]` is high. It stays high while some flag of that channel remains high, and it falls one edge after all of them are low, or once the channel has latched a short.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| run_en | input | 1 | Chip enable; low means standby and asynchronously clears all state |
| dc_mode | input | 1 | 0 = stepper (shutdown of all channels), 1 = per-channel shutdown |
| thermal_flag | input | 1 | Over-temperature indication |
| oc_flag | input | NCH*NSW | Per-switch overcurrent flags, bit c*NSW+s |
| chg_blank | input | NCH | Per-channel forced-charge blanking window from the chopper |
| bridge_off | output | NCH | Registered per-channel bridge disable |
| hold_charge | output | NCH | Registered request to keep the chopper in charge |
| warn_n | output | 1 | Registered active-low fault warning |

## Verification
Several properties are checked on every cycle: the warning agrees with the disable vector, stepper mode never disables only part of the bridges, a latched short never releases while enabled, an over-temperature sample forces every channel off two edges later, and a charge hold never appears without a flag of that channel. Other behaviour can only be shown by the bench's scenarios: the exact edge on which a persisting flag is confirmed, the miss one cycle short of it, the counter restart on a one-cycle dropout, the per-channel disable pattern, self-recovery after over-temperature with a latched short underneath, and clearing through standby.

// File: rtl/fm_pkg.sv
package fm_pkg;
   typedef enum logic {
      SCOPE_ALL  = 1'b0,
      SCOPE_CHAN = 1'b1
   } scope_e;
endpackage

// File: rtl/fm_persist.sv
module fm_persist #(
   parameter int PERSIST_CYC = 400
) (
   input  logic clk,
   input  logic run_en,
   input  logic flag,
   output logic trip
);
   localparam int CNT_W = $clog2(PERSIST_CYC + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERSIST_CYC - 1);

   logic [CNT_W-1:0] cnt;

   // trip marks the edge on which the flag completes its run
   assign trip = flag && (cnt == LAST);

   always_ff @(posedge clk or negedge run_en) begin
      if (!run_en)
         cnt <= '0;
      else if (!flag)
         cnt <= '0;
      else if (cnt != LAST)
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/fm_chan.sv
module fm_chan #(
   parameter int NSW         = 4,
   parameter int PERSIST_CYC = 400
) (
   input  logic           clk,
   input  logic           run_en,
   input  logic [NSW-1:0] flags,
   input  logic           blank,
   output logic           short_lat,
   output logic           hold
);
   logic [NSW-1:0] trip;
   logic           any_flag;

   for (genvar s = 0; s < NSW; s++) begin : g_sw
      fm_persist #(.PERSIST_CYC(PERSIST_CYC)) i_persist (
         .clk   (clk),
         .run_en(run_en),
         .flag  (flags[s]),
         .trip  (trip[s])
      );
   end

   assign any_flag = |flags;

   always_ff @(posedge clk or negedge run_en) begin
      if (!run_en) begin
         short_lat <= 1'b0;
         hold      <= 1'b0;
      end else begin
         short_lat <= short_lat | (|trip);
         hold      <= any_flag & (blank | hold) & ~short_lat & ~(|trip);
      end
   end
endmodule

// File: rtl/short_fault_mgr.sv
module short_fault_mgr
   import fm_pkg::*;
#(
   parameter int NCH         = 2,
   parameter int NSW         = 4,
   parameter int PERSIST_CYC = 400
) (
   input  logic               clk,
   input  logic               run_en,
   input  logic               dc_mode,
   input  logic               thermal_flag,
   input  logic [NCH*NSW-1:0] oc_flag,
   input  logic [NCH-1:0]     chg_blank,
   output logic [NCH-1:0]     bridge_off,
   output logic [NCH-1:0]     hold_charge,
   output logic               warn_n
);
   if (NCH < 1) begin : g_bad_nch
      $error("NCH must be at least 1");
   end
   if (NSW < 1) begin : g_bad_nsw
      $error("NSW must be at least 1");
   end
   if (PERSIST_CYC < 2) begin : g_bad_persist
      $error("PERSIST_CYC must be at least 2");
   end

   logic [NCH-1:0] short_lat;
   logic [NCH-1:0] off_next;
   logic           therm_q;
   scope_e         scope;

   assign scope = scope_e'(dc_mode);

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      fm_chan #(.NSW(NSW), .PERSIST_CYC(PERSIST_CYC)) i_chan (
         .clk      (clk),
         .run_en   (run_en),
         .flags    (oc_flag[c*NSW +: NSW]),
         .blank    (chg_blank[c]),
         .short_lat(short_lat[c]),
         .hold     (hold_charge[c])
      );
   end

   always_comb begin
      if (therm_q)
         off_next = '1;
      else if (scope == SCOPE_ALL)
         off_next = {NCH{|short_lat}};
      else
         off_next = short_lat;
   end

   always_ff @(posedge clk or negedge run_en) begin
      if (!run_en) begin
         therm_q    <= 1'b0;
         bridge_off <= '0;
         warn_n     <= 1'b1;
      end else begin
         therm_q    <= thermal_flag;
         bridge_off <= off_next;
         warn_n     <= ~(therm_q | (|short_lat));
      end
   end
endmodule

// File: rtl/fm_chk.sv
module fm_chk #(
   parameter int NCH = 2,
   parameter int NSW = 4
) (
   input logic               clk,
   input logic               run_en,
   input logic               dc_mode,
   input logic               thermal_flag,
   input logic [NCH*NSW-1:0] oc_flag,
   input logic [NCH-1:0]     bridge_off,
   input logic [NCH-1:0]     hold_charge,
   input logic [NCH-1:0]     short_lat,
   input logic               warn_n
);
   // R8
   warn_match_chk: assert property (@(posedge clk) disable iff (!run_en)
      warn_n == ~(|bridge_off));

   // R4
   stepper_all_chk: assert property (@(posedge clk) disable iff (!run_en)
      !$past(dc_mode) |-> (bridge_off == '0 || bridge_off == '1));

   // R7
   thermal_off_chk: assert property (@(posedge clk) disable iff (!run_en)
      $past(thermal_flag, 2) |-> (bridge_off == '1));

   for (genvar c = 0; c < NCH; c++) begin : g_c
      // R6
      latch_sticky_chk: assert property (@(posedge clk) disable iff (!run_en)
         short_lat[c] |=> short_lat[c]);

      // R2
      latch_cause_chk: assert property (@(posedge clk) disable iff (!run_en)
         $rose(short_lat[c]) |-> $past(|oc_flag[c*NSW +: NSW]));

      // R9
      hold_cause_chk: assert property (@(posedge clk) disable iff (!run_en)
         hold_charge[c] |-> $past(|oc_flag[c*NSW +: NSW]));
   end
endmodule

bind short_fault_mgr fm_chk #(.NCH(NCH), .NSW(NSW)) i_fm_chk (
   .clk         (clk),
   .run_en      (run_en),
   .dc_mode     (dc_mode),
   .thermal_flag(thermal_flag),
   .oc_flag     (oc_flag),
   .bridge_off  (bridge_off),
   .hold_charge (hold_charge),
   .short_lat   (short_lat),
   .warn_n      (warn_n)
);

// File: tb/test_short_fault_mgr.sv
`timescale 1ns/1ps
module test_short_fault_mgr;
   localparam int NCH = 2;
   localparam int NSW = 4;
   localparam int PC  = 8;

   logic           clk = 1'b0;
   logic           run_en = 1'b0;
   logic           dc_mode = 1'b0;
   logic           thermal_flag = 1'b0;
   logic [7:0]     oc_flag = '0;
   logic [1:0]     chg_blank = '0;
   logic [1:0]     bridge_off;
   logic [1:0]     hold_charge;
   logic           warn_n;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   short_fault_mgr #(.NCH(NCH), .NSW(NSW), .PERSIST_CYC(PC)) i_short_fault_mgr (
      .clk(clk), .run_en(run_en), .dc_mode(dc_mode), .thermal_flag(thermal_flag),
      .oc_flag(oc_flag), .chg_blank(chg_blank), .bridge_off(bridge_off),
      .hold_charge(hold_charge), .warn_n(warn_n)
   );

   typedef struct packed {
      logic       dc;
      logic [7:0] oc;
      logic [7:0] len;
      logic [1:0] exp_off;
      logic       exp_warn_n;
   } vec_t;

   localparam vec_t VEC [0:5] = '{
      '{1'b0, 8'h01, 8'd8,  2'b11, 1'b0},
      '{1'b0, 8'h40, 8'd7,  2'b00, 1'b1},
      '{1'b1, 8'h80, 8'd8,  2'b10, 1'b0},
      '{1'b1, 8'h02, 8'd12, 2'b01, 1'b0},
      '{1'b0, 8'h10, 8'd20, 2'b11, 1'b0},
      '{1'b1, 8'h00, 8'd10, 2'b00, 1'b1}
   };
   localparam string VTAG [0:5] = '{"R4", "R2", "R5", "R5", "R6", "R2"};

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic standby();
      run_en = 1'b0;
      oc_flag = '0;
      thermal_flag = 1'b0;
      chg_blank = '0;
      tick(1);
      run_en = 1'b1;
      tick(1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      tick(2);
      // R1 reset state
      check("R1 off", {6'd0, bridge_off}, 8'h00);
      check("R1 warn", {7'd0, warn_n}, 8'h01);
      check("R1 hold", {6'd0, hold_charge}, 8'h00);

      // table of persistence and scope vectors
      for (int i = 0; i < 6; i++) begin
         standby();
         dc_mode = VEC[i].dc;
         oc_flag = VEC[i].oc;
         tick(int'(VEC[i].len));
         oc_flag = '0;
         tick(4);
         check({VTAG[i], " off"}, {6'd0, bridge_off}, {6'd0, VEC[i].exp_off});
         check({VTAG[i], " warn"}, {7'd0, warn_n}, {7'd0, VEC[i].exp_warn_n});
      end

      // R1: standby clears a latched short
      standby();
      check("R1 clear", {6'd0, bridge_off}, 8'h00);
      check("R1 clear warn", {7'd0, warn_n}, 8'h01);

      // R3: one-cycle dropout restarts the count
      dc_mode = 1'b0;
      oc_flag = 8'h04;
      tick(PC - 1);
      oc_flag = 8'h00;
      tick(1);
      oc_flag = 8'h04;
      tick(PC - 1);
      oc_flag = 8'h00;
      tick(3);
      check("R3 restart", {6'd0, bridge_off}, 8'h00);

      // R2 exact edge: off appears one edge after the latch
      standby();
      dc_mode = 1'b1;
      oc_flag = 8'h01;
      tick(PC);
      check("R2 not yet", {6'd0, bridge_off}, 8'h00);
      tick(1);
      check("R2 edge", {6'd0, bridge_off}, 8'h01);
      oc_flag = 8'h00;

      // R7 thermal over a latched short in DC mode
      thermal_flag = 1'b1;
      tick(1);
      check("R7 lag", {6'd0, bridge_off}, 8'h01);
      tick(1);
      check("R7 all off", {6'd0, bridge_off}, 8'h03);
      thermal_flag = 1'b0;
      tick(2);
      check("R7 recover to short", {6'd0, bridge_off}, 8'h01);
      check("R8 warn held", {7'd0, warn_n}, 8'h00);

      // R7 thermal alone recovers fully
      standby();
      dc_mode = 1'b0;
      thermal_flag = 1'b1;
      tick(2);
      check("R7 thermal", {6'd0, bridge_off}, 8'h03);
      check("R8 thermal warn", {7'd0, warn_n}, 8'h00);
      thermal_flag = 1'b0;
      tick(2);
      check("R7 self clear", {6'd0, bridge_off}, 8'h00);
      check("R8 warn clear", {7'd0, warn_n}, 8'h01);

      // R9 charge hold
      standby();
      oc_flag = 8'h01;
      tick(1);
      check("R9 no blank", {6'd0, hold_charge}, 8'h00);
      chg_blank = 2'b01;
      tick(1);
      check("R9 rise", {6'd0, hold_charge}, 8'h01);
      chg_blank = 2'b00;
      tick(1);
      check("R9 keep", {6'd0, hold_charge}, 8'h01);
      oc_flag = 8'h00;
      tick(1);
      check("R9 fall", {6'd0, hold_charge}, 8'h00);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule